// File: doc/BRIEF.md
# Strobed Asynchronous Packet FIFO Ingress

This block receives bytes from an external agent that has no shared clock. The agent chooses one of several internal packet FIFOs with a select field and holds chip select low. It then pulses an active-low write strobe with a byte on the data bus. The block passes the strobes through a flop synchroniser chain into its own clock domain. A byte is taken on the trailing (rising) edge of each write pulse. The byte is stored at the selected FIFO's write location, and the pointer then moves on by one.

Bytes stay invisible to the reader until the agent pulses an active-low packet-end strobe. That pulse commits everything written so far to the selected FIFO, so a short packet can be closed at any length. A packet-end that finds nothing to commit leaves a zero-length packet marker instead. The read side is a synchronous pop port: the reader picks a FIFO, looks at its committed byte count, and pops the head byte.

Top module: `strobe_fifo_ingress`

## Requirements
- R1: A byte is stored only on the trailing (low-to-high) edge of the write strobe. While the strobe is held low, no FIFO fill level changes.
- R2: Bytes are stored at the write pointer, which then advances, so the reader sees them in write order and the fill level rises by exactly one per pulse.
- R3: A write or packet-end pulse whose chip select is high (inactive) has no effect on any FIFO.
- R4: The empty and full flags of the selected FIFO change on the third clock edge after the strobe's trailing edge, and not on the second. Full means 16 stored bytes and empty means 0 stored bytes.
- R5: A write to a full FIFO is dropped and sets that FIFO's sticky overflow bit (bit i for FIFO i).
- R6: The trailing edge of packet-end commits all uncommitted bytes of the FIFO named by the select lines. Only committed bytes can be popped, and a pop with zero committed bytes changes nothing.
- R7: A packet-end with zero uncommitted bytes sets the FIFO's zero-length marker bit. A pop with zero committed bytes clears that bit.
- R8: If the write strobe and packet-end are low together, the write is still performed, that packet-end is ignored, and the sticky protocol error flag is set.
- R9: After reset, every FIFO is empty and not full, all counts are zero, and the overflow, marker and error flags are clear.
- R10: A write or commit changes only the FIFO named by the select lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_sel | input | 2 | FIFO select from the agent |
| ext_cs_n | input | 1 | Chip select, active low |
| ext_wr_n | input | 1 | Write strobe, active low |
| ext_data | input | 8 | Write data byte |
| ext_pktend_n | input | 1 | Packet-end strobe, active low |
| rd_sel | input | 2 | FIFO chosen by the reader |
| rd_pop | input | 1 | Pop the head byte of the chosen FIFO |
| rd_data | output | 8 | Head byte of the chosen FIFO |
| rd_fill | output | 5 | Stored bytes (committed and not) of the chosen FIFO |
| rd_avail | output | 5 | Committed bytes of the chosen FIFO |
| fifo_full | output | 4 | Full flag per FIFO |
| fifo_empty | output | 4 | Empty flag per FIFO |
| fifo_zlp | output | 4 | Zero-length packet marker per FIFO |
| fifo_ovf | output | 4 | Sticky overflow per FIFO |
| proto_err | output | 1 | Sticky write/packet-end overlap error |

## Verification
A strobe edge reaches the FIFO state after three clock edges: two synchroniser flops and the edge-detect register. Fill, committed count and flags are therefore all due on the third edge after a trailing strobe edge. A pop acts on the next edge. The bench changes inputs on falling edges and holds each strobe level for three cycles or more. It samples the results two falling edges after the last strobe change, which leaves a safe margin. The flag-timing check for R4 instead samples on the second and third falling edges after the edge, so both the value before the update and the value after it are seen.

// File: rtl/strobe_fifo_pkg.sv
package strobe_fifo_pkg;
   typedef enum logic [1:0] {
      EV_IDLE   = 2'd0,
      EV_STORE  = 2'd1,
      EV_COMMIT = 2'd2
   } sfi_event_t;

   typedef struct packed {
      logic pk_n;
      logic cs_n;
      logic wr_n;
   } sfi_strobes_t;
endpackage

// File: rtl/sfi_sync.sv
module sfi_sync #(
   parameter int WIDTH     = 3,
   parameter int STAGES    = 2,
   parameter bit RESET_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);
   logic [WIDTH-1:0] chain [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sfi_sync needs two or more stages");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= {WIDTH{RESET_VAL}};
            else if (s == 0) chain[s] <= async_in;
            else chain[s] <= chain[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/sfi_lane.sv
module sfi_lane
   import strobe_fifo_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int AW     = 4,
   localparam int DEPTH = 1 << AW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  sfi_event_t        ev,
   input  logic              hit,
   input  logic [DATA_W-1:0] wdata,
   input  logic              pop,
   output logic [DATA_W-1:0] rdata,
   output logic [AW:0]       fill,
   output logic [AW:0]       avail,
   output logic              full,
   output logic              empty,
   output logic              zlp,
   output logic              ovf
);
   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW:0] wptr, rptr, cptr;

   assign fill  = wptr - rptr;
   assign avail = cptr - rptr;
   assign full  = (fill == (AW+1)'(DEPTH));
   assign empty = (fill == '0);
   assign rdata = mem[rptr[AW-1:0]];

   always_ff @(posedge clk) begin
      if (hit && ev == EV_STORE && !full) mem[wptr[AW-1:0]] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         cptr <= '0;
         zlp  <= 1'b0;
         ovf  <= 1'b0;
      end else begin
         if (pop) begin
            if (avail != '0) rptr <= rptr + 1'b1;
            else zlp <= 1'b0;
         end
         if (hit && ev == EV_STORE) begin
            if (full) ovf <= 1'b1;
            else wptr <= wptr + 1'b1;
         end
         if (hit && ev == EV_COMMIT) begin
            if (wptr == cptr) zlp <= 1'b1;
            else cptr <= wptr;
         end
      end
   end
endmodule

// File: rtl/strobe_fifo_ingress.sv
module strobe_fifo_ingress
   import strobe_fifo_pkg::*;
#(
   parameter int SEL_W       = 2,
   parameter int DATA_W      = 8,
   parameter int AW          = 4,
   parameter int SYNC_STAGES = 2,
   localparam int NUM        = 1 << SEL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEL_W-1:0]  ext_sel,
   input  logic              ext_cs_n,
   input  logic              ext_wr_n,
   input  logic [DATA_W-1:0] ext_data,
   input  logic              ext_pktend_n,
   input  logic [SEL_W-1:0]  rd_sel,
   input  logic              rd_pop,
   output logic [DATA_W-1:0] rd_data,
   output logic [AW:0]       rd_fill,
   output logic [AW:0]       rd_avail,
   output logic [NUM-1:0]    fifo_full,
   output logic [NUM-1:0]    fifo_empty,
   output logic [NUM-1:0]    fifo_zlp,
   output logic [NUM-1:0]    fifo_ovf,
   output logic              proto_err
);
   generate
      if (AW < 1 || DATA_W < 1 || SEL_W < 1) begin : g_bad_cfg
         $error("strobe_fifo_ingress: widths must be positive");
      end
   endgenerate

   sfi_strobes_t raw_s, syn_s, dly_s;
   logic wr_rise, pk_rise, cs_act, clash;
   sfi_event_t ev;

   assign raw_s = '{pk_n: ext_pktend_n, cs_n: ext_cs_n, wr_n: ext_wr_n};

   sfi_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(raw_s), .sync_out(syn_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dly_s <= '1;
      else dly_s <= syn_s;
   end

   assign wr_rise = syn_s.wr_n & ~dly_s.wr_n;
   assign pk_rise = syn_s.pk_n & ~dly_s.pk_n;
   assign cs_act  = ~dly_s.cs_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) clash <= 1'b0;
      else if (pk_rise) clash <= 1'b0;
      else if (!syn_s.pk_n && !syn_s.wr_n) clash <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) proto_err <= 1'b0;
      else if (pk_rise && cs_act && (clash || !syn_s.wr_n)) proto_err <= 1'b1;
   end

   always_comb begin
      ev = EV_IDLE;
      if (cs_act) begin
         if (wr_rise) ev = EV_STORE;
         else if (pk_rise && !clash && syn_s.wr_n) ev = EV_COMMIT;
      end
   end

   logic [DATA_W-1:0]   lane_rdata [NUM];
   logic [AW:0]         lane_fill  [NUM];
   logic [AW:0]         lane_avail [NUM];
   logic [NUM*(AW+1)-1:0] fill_flat;

   generate
      for (genvar i = 0; i < NUM; i++) begin : g_lane
         sfi_lane #(.DATA_W(DATA_W), .AW(AW)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .ev    (ev),
            .hit   (ext_sel == SEL_W'(i)),
            .wdata (ext_data),
            .pop   (rd_pop && rd_sel == SEL_W'(i)),
            .rdata (lane_rdata[i]),
            .fill  (lane_fill[i]),
            .avail (lane_avail[i]),
            .full  (fifo_full[i]),
            .empty (fifo_empty[i]),
            .zlp   (fifo_zlp[i]),
            .ovf   (fifo_ovf[i])
         );
         assign fill_flat[i*(AW+1) +: AW+1] = lane_fill[i];
      end
   endgenerate

   assign rd_data  = lane_rdata[rd_sel];
   assign rd_fill  = lane_fill[rd_sel];
   assign rd_avail = lane_avail[rd_sel];
endmodule

// File: rtl/sfi_checker.sv
module sfi_checker #(
   parameter int NUM = 4,
   parameter int AW  = 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  s_wr_n,
   input logic                  rd_pop,
   input logic [NUM*(AW+1)-1:0] fill_flat,
   input logic [NUM-1:0]        full,
   input logic [NUM-1:0]        empty,
   input logic [NUM-1:0]        ovf,
   input logic                  err
);
   // R1: synchronised strobe low and no pop, so no fill level may move
   a_r1_no_store_low: assert property (@(posedge clk) disable iff (!rst_n)
      (!s_wr_n && !rd_pop) |=> $stable(fill_flat));

   // R8: error flag is sticky
   a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);

   generate
      for (genvar i = 0; i < NUM; i++) begin : g_lane_chk
         // R4: flags exclusive
         a_r4_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
            !(full[i] && empty[i]));
         // R5: overflow sticky
         a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            ovf[i] |=> ovf[i]);
         // R5: a full FIFO stays full until a pop
         a_r5_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (full[i] && !rd_pop) |=> full[i]);
      end
   endgenerate
endmodule

bind strobe_fifo_ingress sfi_checker #(.NUM(NUM), .AW(AW)) u_sfi_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .s_wr_n    (syn_s.wr_n),
   .rd_pop    (rd_pop),
   .fill_flat (fill_flat),
   .full      (fifo_full),
   .empty     (fifo_empty),
   .ovf       (fifo_ovf),
   .err       (proto_err)
);

// File: tb/strobe_fifo_ingress_bench.sv
module strobe_fifo_ingress_bench;
   logic clk = 1'b0, rst_n = 1'b0;
   logic [1:0] ext_sel = '0, rd_sel = '0;
   logic ext_cs_n = 1'b1, ext_wr_n = 1'b1, ext_pktend_n = 1'b1, rd_pop = 1'b0;
   logic [7:0] ext_data = '0, rd_data;
   logic [4:0] rd_fill, rd_avail;
   logic [3:0] fifo_full, fifo_empty, fifo_zlp, fifo_ovf;
   logic proto_err;
   int n_run = 0, n_fail = 0, cyc = 0;

   always #2 clk = ~clk;

   strobe_fifo_ingress u_strobe_fifo_ingress (.*);

   typedef struct packed {
      logic [1:0] op;   // 0 write, 1 write with cs high, 2 packet-end, 3 pop
      logic [1:0] sel;
      logic [7:0] data; // pop: expected head byte, 0 = no data check
      logic [4:0] fill;
      logic [4:0] avail;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VEC [NV] = '{
      '{2'd0, 2'd0, 8'hA1, 5'd1, 5'd0},   // R2
      '{2'd0, 2'd0, 8'hA2, 5'd2, 5'd0},
      '{2'd0, 2'd0, 8'hA3, 5'd3, 5'd0},
      '{2'd0, 2'd0, 8'hA4, 5'd4, 5'd0},
      '{2'd2, 2'd0, 8'h00, 5'd4, 5'd4},   // R6 four-byte short packet
      '{2'd1, 2'd0, 8'h55, 5'd4, 5'd4},   // R3
      '{2'd0, 2'd2, 8'hB1, 5'd1, 5'd0},   // R10
      '{2'd3, 2'd0, 8'hA1, 5'd3, 5'd3},   // R2 order
      '{2'd3, 2'd0, 8'hA2, 5'd2, 5'd2},
      '{2'd0, 2'd0, 8'hA5, 5'd3, 5'd2},
      '{2'd3, 2'd0, 8'hA3, 5'd2, 5'd1},
      '{2'd3, 2'd0, 8'hA4, 5'd1, 5'd0},
      '{2'd3, 2'd0, 8'h00, 5'd1, 5'd0}    // R6 pop with nothing committed
   };

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cyc_wait(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic strobe(input logic [1:0] sel, input logic [7:0] d,
                         input bit use_cs, input bit is_pk);
      ext_sel = sel; ext_data = d; ext_cs_n = !use_cs;
      cyc_wait(1);
      if (is_pk) ext_pktend_n = 1'b0; else ext_wr_n = 1'b0;
      cyc_wait(3);
      ext_pktend_n = 1'b1; ext_wr_n = 1'b1;
      cyc_wait(3);
      ext_cs_n = 1'b1;
      cyc_wait(2);
   endtask

   task automatic pop_one(input logic [1:0] sel);
      rd_sel = sel; rd_pop = 1'b1;
      cyc_wait(1);
      rd_pop = 1'b0;
      cyc_wait(1);
   endtask

   task automatic finish_run;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual %0d expected below 50000", cyc);
         finish_run();
      end
   end

   initial begin
      cyc_wait(3);
      // R9 reset state
      chk("R9 empty", fifo_empty, 4'hF);
      chk("R9 full", fifo_full, 0);
      chk("R9 fill", rd_fill, 0);
      chk("R9 avail", rd_avail, 0);
      chk("R9 flags", {fifo_zlp, fifo_ovf, proto_err}, 0);
      rst_n = 1'b1;
      cyc_wait(2);

      for (int v = 0; v < NV; v++) begin
         rd_sel = VEC[v].sel;
         cyc_wait(1);
         case (VEC[v].op)
            2'd0: strobe(VEC[v].sel, VEC[v].data, 1'b1, 1'b0);
            2'd1: strobe(VEC[v].sel, VEC[v].data, 1'b0, 1'b0);
            2'd2: strobe(VEC[v].sel, VEC[v].data, 1'b1, 1'b1);
            default: begin
               if (VEC[v].data != 0) chk("R2 head byte", rd_data, VEC[v].data);
               pop_one(VEC[v].sel);
            end
         endcase
         chk("R2/R3/R6/R10 fill", rd_fill, VEC[v].fill);
         chk("R2/R3/R6/R10 avail", rd_avail, VEC[v].avail);
      end
      chk("R10 untouched lanes empty", {fifo_empty[3], fifo_empty[1]}, 2'b11);

      // R4 flag timing on lane 1
      ext_sel = 2'd1; ext_data = 8'hC1; ext_cs_n = 1'b0;
      cyc_wait(1);
      ext_wr_n = 1'b0;
      cyc_wait(4);
      ext_wr_n = 1'b1;
      cyc_wait(2);
      chk("R4 empty before third edge", fifo_empty[1], 1);
      cyc_wait(1);
      chk("R4 empty cleared on third edge", fifo_empty[1], 0);
      cyc_wait(3);
      ext_cs_n = 1'b1;
      cyc_wait(2);

      // R1 strobe held low on lane 3
      rd_sel = 2'd3; ext_sel = 2'd3; ext_data = 8'hD0; ext_cs_n = 1'b0;
      cyc_wait(1);
      ext_wr_n = 1'b0;
      cyc_wait(20);
      chk("R1 nothing stored while low", rd_fill, 0);
      ext_wr_n = 1'b1;
      cyc_wait(4);
      chk("R1 stored after trailing edge", rd_fill, 1);
      ext_cs_n = 1'b1;
      cyc_wait(2);

      // R4/R5 fill lane 3 to 16, then overflow
      for (int k = 1; k < 16; k++) strobe(2'd3, 8'hD0 + 8'(k), 1'b1, 1'b0);
      chk("R4 full at 16", fifo_full[3], 1);
      chk("R5 no overflow yet", fifo_ovf[3], 0);
      strobe(2'd3, 8'hEE, 1'b1, 1'b0);
      chk("R5 overflow set", fifo_ovf, 4'b1000);
      chk("R5 fill held at 16", rd_fill, 16);
      strobe(2'd3, 8'h00, 1'b1, 1'b1);
      chk("R6 commit of 16", rd_avail, 16);
      chk("R2 head of lane 3", rd_data, 8'hD0);

      // R7 zero-length marker on lane 1
      rd_sel = 2'd1;
      strobe(2'd1, 8'h00, 1'b1, 1'b1);
      chk("R7 commit one byte", rd_avail, 1);
      chk("R7 no marker yet", fifo_zlp[1], 0);
      strobe(2'd1, 8'h00, 1'b1, 1'b1);
      chk("R7 marker set", fifo_zlp, 4'b0010);
      chk("R7 head byte", rd_data, 8'hC1);
      pop_one(2'd1);
      chk("R7 marker kept while data popped", fifo_zlp[1], 1);
      pop_one(2'd1);
      chk("R7 marker cleared", fifo_zlp[1], 0);

      // R8 overlap on lane 2
      chk("R8 error clear before", proto_err, 0);
      rd_sel = 2'd2; ext_sel = 2'd2; ext_data = 8'hB2; ext_cs_n = 1'b0;
      cyc_wait(1);
      ext_wr_n = 1'b0; ext_pktend_n = 1'b0;
      cyc_wait(4);
      ext_wr_n = 1'b1;
      cyc_wait(4);
      ext_pktend_n = 1'b1;
      cyc_wait(4);
      ext_cs_n = 1'b1;
      cyc_wait(2);
      chk("R8 write performed", rd_fill, 2);
      chk("R8 packet-end ignored", rd_avail, 0);
      chk("R8 error set", proto_err, 1);

      finish_run();
   end
endmodule